// File: doc/BRIEF.md
# ECC Error Status Flag Register

This block gathers error reports from a set of ECC decoders and keeps one sticky flag per decoder and per error kind: one flag for correctable single-bit errors and one for uncorrectable double-bit errors. Each decoder presents a beat stream made of a beat-valid strobe, a first-beat marker that opens a new transfer, and two error strobes. Only the first erroneous beat of a transfer sets a flag. Once set, a flag holds until software writes a one to it.

Software reaches the flags through a simple register port at byte offset 0x84. It writes ones to clear flags and reads the flag word with one cycle of latency. Two level interrupts summarise the single-bit and double-bit flag groups. The decoder beat inputs carry a valid strobe but no ready. The block samples a report on every clock edge, so it never applies back-pressure and a decoder never has to hold a beat. The ECC enable input has no influence on any flag.

Top module: `ecc_flag_status`

## Requirements
- R1: While reset is asserted and right after it, every flag is 0, both interrupts are 0 and a read returns 0.
- R2: A valid beat with the single-error strobe from decoder n sets bit n of the flag word.
- R3: A valid beat with the double-error strobe from decoder n sets bit 8+n of the flag word.
- R4: A set flag stays 1 whatever further errors arrive, until software clears it.
- R5: A write to offset 0x84 clears each flag whose write-data bit is 1 and leaves flags with a 0 bit unchanged.
- R6: When a hardware set and a write-one-clear hit the same flag in the same cycle, the flag ends at 1.
- R7: Within one transfer, only the first beat that carries a given error kind sets that flag. A later erroneous beat of that transfer does not set it again, even after a clear. A beat with the first-beat marker starts a new transfer. Beats without beat-valid are ignored.
- R8: Bits 31:16 always read as 0, and writing ones to them changes no flag.
- R9: With fewer than 8 decoders, the bits of the absent decoders (n and 8+n) read as 0.
- R10: A change of the ECC enable input, including its deassertion, neither sets nor clears any flag.
- R11: A read is registered: the read data after a read cycle is the flag word if the address is 0x84, or 0 otherwise. The read data holds while no read is issued. A write to any other address clears nothing.
- R12: The single-error interrupt is the OR of bits 7:0 and the double-error interrupt is the OR of bits 15:8, and both change in the same cycle as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | ECC enable control; has no effect on the flags |
| dec_beat_valid | input | NUM_DEC | Per-decoder beat valid |
| dec_first_beat | input | NUM_DEC | Per-decoder marker for the first beat of a transfer |
| dec_single_err | input | NUM_DEC | Per-decoder single-bit error on this beat |
| dec_double_err | input | NUM_DEC | Per-decoder double-bit error on this beat |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data, ones clear flags |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| irq_single | output | 1 | OR of the single-bit error flags |
| irq_double | output | 1 | OR of the double-bit error flags |

## Verification
The assertions assume that the error strobes only count together with beat-valid, and that the decoders may raise a first-beat marker on any beat. They also assume that the enable check only covers cycles with no register write, so that a write-one-clear is not mistaken for a flag lost to the enable. The stimulus drives the beat inputs and the bus strobes at the falling edge, and releases the beat inputs on an idle cycle before each read. The enable is toggled only while the bus is quiet.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;
  localparam int MAX_DEC  = 8;
  localparam int REG_W    = 32;
  localparam int SBE_LSB  = 0;
  localparam int DBE_LSB  = 8;
  localparam int RSVD_LSB = 16;
  localparam int RSVD_W   = REG_W - RSVD_LSB;

  typedef enum logic {
    KIND_SINGLE = 1'b0,
    KIND_DOUBLE = 1'b1
  } err_kind_e;
endpackage

// File: rtl/ecc_first_err_detect.sv
module ecc_first_err_detect #(
  parameter int NUM_DEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEC-1:0] beat_valid,
  input  logic [NUM_DEC-1:0] first_beat,
  input  logic [NUM_DEC-1:0] single_err,
  input  logic [NUM_DEC-1:0] double_err,
  output logic [NUM_DEC-1:0] set_single,
  output logic [NUM_DEC-1:0] set_double
);
  import ecc_stat_pkg::*;

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
    for (genvar k = 0; k < 2; k++) begin : g_kind
      localparam err_kind_e KIND = err_kind_e'(k);
      logic err;
      logic seen_q;
      logic seen_d;
      logic set;

      assign err = (KIND == KIND_DOUBLE) ? double_err[d] : single_err[d];
      assign set = beat_valid[d] && err && (first_beat[d] || !seen_q);

      always_comb begin
        seen_d = seen_q;
        if (beat_valid[d]) begin
          seen_d = first_beat[d] ? err : (seen_q || err);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
      end

      AST_NO_REPEAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> (first_beat[d] || !set)); // R7
    end

    assign set_single[d] = g_kind[0].set;
    assign set_double[d] = g_kind[1].set;
  end
endmodule

// File: rtl/ecc_w1c_flag.sv
module ecc_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> !q); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    q && !clr |=> q); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    q && clr && !set |=> !q); // R5
endmodule

// File: rtl/ecc_reg_port.sv
module ecc_reg_port #(
  parameter int NUM_DEC    = 8,
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h84
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            wr_en,
  input  logic [ecc_stat_pkg::REG_W-1:0]  wr_data,
  input  logic                            rd_en,
  input  logic [ecc_stat_pkg::REG_W-1:0]  flag_word,
  output logic [NUM_DEC-1:0]              clr_single,
  output logic [NUM_DEC-1:0]              clr_double,
  output logic [ecc_stat_pkg::REG_W-1:0]  rd_data
);
  import ecc_stat_pkg::*;

  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);

  logic addr_hit;
  logic wr_hit;
  logic rsvd_write;

  assign addr_hit   = (addr == OFF);
  assign wr_hit     = wr_en && addr_hit;
  assign clr_single = wr_hit ? wr_data[SBE_LSB +: NUM_DEC] : '0;
  assign clr_double = wr_hit ? wr_data[DBE_LSB +: NUM_DEC] : '0;
  assign rsvd_write = wr_hit && (|wr_data[RSVD_LSB +: RSVD_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= addr_hit ? flag_word : '0;
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RSVD_LSB +: RSVD_W] == '0); // R8
  AST_RSVD_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_write |-> (flag_word[RSVD_LSB +: RSVD_W] == '0)); // R8
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr_hit |=> rd_data == $past(flag_word)); // R11
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R11
endmodule

// File: rtl/ecc_flag_status.sv
module ecc_flag_status #(
  parameter int NUM_DEC    = 8,
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h84
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ecc_en,
  input  logic [NUM_DEC-1:0]              dec_beat_valid,
  input  logic [NUM_DEC-1:0]              dec_first_beat,
  input  logic [NUM_DEC-1:0]              dec_single_err,
  input  logic [NUM_DEC-1:0]              dec_double_err,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_wr_en,
  input  logic [ecc_stat_pkg::REG_W-1:0]  bus_wr_data,
  input  logic                            bus_rd_en,
  output logic [ecc_stat_pkg::REG_W-1:0]  bus_rd_data,
  output logic                            irq_single,
  output logic                            irq_double
);
  import ecc_stat_pkg::*;

  localparam int FLAG_N = 2 * NUM_DEC;

  logic [NUM_DEC-1:0] set_single, set_double;
  logic [NUM_DEC-1:0] clr_single, clr_double;
  logic [NUM_DEC-1:0] single_q, double_q;
  logic [FLAG_N-1:0]  flag_vec;
  logic [REG_W-1:0]   flag_word;

  ecc_first_err_detect #(.NUM_DEC(NUM_DEC)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (dec_beat_valid),
    .first_beat (dec_first_beat),
    .single_err (dec_single_err),
    .double_err (dec_double_err),
    .set_single (set_single),
    .set_double (set_double)
  );

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_flag
    ecc_w1c_flag u_single (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_single[d]),
      .clr   (clr_single[d]),
      .q     (single_q[d])
    );
    ecc_w1c_flag u_double (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_double[d]),
      .clr   (clr_double[d]),
      .q     (double_q[d])
    );
  end

  always_comb begin
    flag_word = '0;
    flag_word[SBE_LSB +: NUM_DEC] = single_q;
    flag_word[DBE_LSB +: NUM_DEC] = double_q;
  end

  assign flag_vec   = {double_q, single_q};
  assign irq_single = |single_q;
  assign irq_double = |double_q;

  ecc_reg_port #(
    .NUM_DEC    (NUM_DEC),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .wr_en      (bus_wr_en),
    .wr_data    (bus_wr_data),
    .rd_en      (bus_rd_en),
    .flag_word  (flag_word),
    .clr_single (clr_single),
    .clr_double (clr_double),
    .rd_data    (bus_rd_data)
  );

  AST_ENABLE_DROP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ecc_en) && !bus_wr_en |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec))); // R10
  AST_IRQ_FOLLOWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_single) |=> irq_single); // R12
  AST_IRQ_DOUBLE_FOLLOWS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_double) |=> irq_double); // R12
  AST_SINGLE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dec_beat_valid & dec_single_err & dec_first_beat)) |=> (single_q != '0)); // R2
  AST_DOUBLE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dec_beat_valid & dec_double_err & dec_first_beat)) |=> (double_q != '0)); // R3
endmodule

// File: tb/test_ecc_flag_status.sv
`timescale 1ns/1ps
module test_ecc_flag_status;
  localparam int NARROW = 3;
  localparam logic [11:0] OFF = 12'h084;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_en = 1'b1;
  logic [7:0] bv = '0, fb = '0, se = '0, de = '0;
  logic [11:0] addr = OFF;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_n;
  logic irq_s, irq_d, irq_s_n, irq_d_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_flag_status i_ecc_flag_status (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
    .dec_beat_valid(bv), .dec_first_beat(fb),
    .dec_single_err(se), .dec_double_err(de),
    .bus_addr(addr), .bus_wr_en(wr_en), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_data(rd_data),
    .irq_single(irq_s), .irq_double(irq_d)
  );

  ecc_flag_status #(.NUM_DEC(NARROW)) i_ecc_flag_status_narrow (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
    .dec_beat_valid(bv[NARROW-1:0]), .dec_first_beat(fb[NARROW-1:0]),
    .dec_single_err(se[NARROW-1:0]), .dec_double_err(de[NARROW-1:0]),
    .bus_addr(addr), .bus_wr_en(wr_en), .bus_wr_data(wr_data),
    .bus_rd_en(rd_en), .bus_rd_data(rd_data_n),
    .irq_single(irq_s_n), .irq_double(irq_d_n)
  );

  // {valid, first, single, double, write, wdata[15:0], expected[15:0]}
  localparam int NV = 14;
  localparam logic [64:0] VEC [NV] = '{
    {8'h01, 8'h01, 8'h01, 8'h00, 1'b0, 16'h0000, 16'h0001}, // R2 first set
    {8'h01, 8'h00, 8'h01, 8'h00, 1'b0, 16'h0000, 16'h0001}, // R4 repeat
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0001, 16'h0000}, // R5 clear
    {8'h01, 8'h00, 8'h01, 8'h00, 1'b0, 16'h0000, 16'h0000}, // R7 same transfer
    {8'h01, 8'h01, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0000}, // R7 new clean transfer
    {8'h01, 8'h00, 8'h01, 8'h00, 1'b0, 16'h0000, 16'h0001}, // R7 first error of it
    {8'h80, 8'h80, 8'h00, 8'h80, 1'b0, 16'h0000, 16'h8001}, // R3
    {8'h06, 8'h06, 8'h02, 8'h04, 1'b0, 16'h0000, 16'h8403}, // R2 R3 mixed
    {8'h00, 8'h00, 8'h10, 8'h00, 1'b0, 16'h0000, 16'h8403}, // R7 not valid
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0400, 16'h8003}, // R5 one bit
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 16'h8003}, // R5 zeros
    {8'h08, 8'h08, 8'h08, 8'h00, 1'b1, 16'h0008, 16'h800B}, // R6 collide
    {8'h80, 8'h00, 8'h00, 8'h80, 1'b0, 16'h0000, 16'h800B}, // R4 more errors
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'hFFFF, 16'h0000}  // R5 all
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 7:        return "R2";
      6:           return "R3";
      1, 12:       return "R4";
      2, 9, 10, 13: return "R5";
      11:          return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(logic [7:0] v, logic [7:0] f, logic [7:0] s, logic [7:0] d,
                      logic w, logic [11:0] a, logic [31:0] wd);
    bv = v; fb = f; se = s; de = d; wr_en = w; addr = a; wr_data = wd;
    @(negedge clk);
    bv = '0; fb = '0; se = '0; de = '0; wr_en = 1'b0; addr = OFF; wr_data = '0;
  endtask

  task automatic read(logic [11:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; addr = OFF;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 32'h0);
    check("R1 irq in reset", {30'h0, irq_s, irq_d}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read(OFF);
    check("R1 read after reset", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i][64:57], VEC[i][56:49], VEC[i][48:41], VEC[i][40:33],
           VEC[i][32], OFF, {16'h0, VEC[i][31:16]});
      read(OFF);
      check(vec_tag(i), rd_data, {16'h0, VEC[i][15:0]});
      check("R12 irq", {30'h0, irq_s, irq_d},
            {30'h0, |VEC[i][7:0], |VEC[i][15:8]});
    end

    // R8: reserved bits
    beat(8'h02, 8'h02, 8'h02, 8'h00, 1'b0, OFF, 32'h0);
    beat(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, OFF, 32'hFFFF_0000);
    read(OFF);
    check("R8 reserved write", rd_data, 32'h0000_0002);

    // R11: other addresses
    beat(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 12'h080, 32'h0000_FFFF);
    read(OFF);
    check("R11 foreign write", rd_data, 32'h0000_0002);
    read(12'h080);
    check("R11 foreign read", rd_data, 32'h0);
    @(negedge clk);
    check("R11 read data holds", rd_data, 32'h0);

    // R10: enable toggling
    ecc_en = 1'b0;
    repeat (2) @(negedge clk);
    ecc_en = 1'b1;
    @(negedge clk);
    ecc_en = 1'b0;
    read(OFF);
    check("R10 enable drop", rd_data, 32'h0000_0002);
    check("R12 irq single only", {30'h0, irq_s, irq_d}, 32'h2);
    ecc_en = 1'b1;

    // R9: narrow instance
    beat(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, OFF, 32'h0);
    read(OFF);
    check("R9 full width", rd_data, 32'h0000_FFFF);
    check("R9 absent decoders", rd_data_n, 32'h0000_0707);

    // R1: reset again
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears read", rd_data, 32'h0);
    check("R1 reset clears irq", {30'h0, irq_s, irq_d}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read(OFF);
    check("R1 flags after reset", rd_data, 32'h0);

    finish_run();
  end
endmodule